// File: doc/BRIEF.md
# Processor Control Register Update Unit

This block keeps the architectural control state of a 32/64-bit core: the mode register (CR0), the page-table base (CR3), the feature register (CR4), the long-mode enable and active bits of the extended feature register, and the address-line-20 gate. A single write port updates one of these per cycle. Each write also updates a set of hidden mode flags that the rest of the core reads every cycle. These flags are protected-mode enable, the segment-base-add flag, the three floating-point trap flags, long-mode active, 64-bit code segment and the extended save-state enable.

The block also decides when long mode is entered or left. A change of the paging bit either switches the mode, is refused with a fault pulse, or leaves the mode unchanged. The block tells the translation cache when its contents have gone stale, and it tells the fetch unit when the instruction pointer has to be cut back to 32 bits. Instruction decode, the translation cache itself and exception delivery are left to neighbouring blocks.

All state changes on the rising clock edge where the write strobe is sampled. The new values, and any pulse, appear in the cycle that follows.

Top module: `ctrl_reg_unit`

## Requirements
- R1: After reset, cr0_o = 0x60000010, a20_mask_o = 0xFFFFFFFF, cr3_o, cr4_o and efer_o are 0, pe_o/mp_o/em_o/ts_o/lma_o/cs64_o/osfxsr_o are 0, addseg_o is 1, and all pulse outputs are 0.
- R2: A write with wr_sel_i = 0 stores wr_data_i[31:0] into cr0_o with bit 4 forced to 1. mp_o, em_o and ts_o take the stored bits 1, 2 and 3.
- R3: pe_o equals cr0_o bit 0, and addseg_o equals its inverse.
- R4: An accepted CR0 write pulses tlb_flush_o exactly when it changes bit 31 (paging), bit 16 (write protect) or bit 0 (protection enable). A write that changes none of these, including a write of the current value, gives no pulse.
- R5: A CR0 write that takes bit 31 from 0 to 1 while efer_o bit 8 (long-mode enable) is 1 is a long-mode entry. If cr4_o bit 5 (PAE) is 0, the write is refused: CR0 is unchanged, mode_fault_o pulses and no flush is raised. Otherwise lma_o and efer_o bit 10 become 1.
- R6: A CR0 write that takes bit 31 from 1 to 0 while long mode is active clears lma_o, efer_o bit 10 and cs64_o, and pulses ip_trunc_o.
- R7: cs64_set_i sets cs64_o only while lma_o is 1. A long-mode exit in the same cycle takes priority over it.
- R8: A write with wr_sel_i = 2 stores wr_data_i[31:0] into cr4_o, with bit 9 forced to 0 when sse_avail_i is 0. osfxsr_o follows the stored bit 9. tlb_flush_o pulses when bit 4, 5 or 7 changes.
- R9: A write with wr_sel_i = 1 always loads cr3_o and pulses tlb_flush_o only if cr0_o bit 31 is 1.
- R10: a20_mask_o is 0xFFEFFFFF while a20_en_i is 0 and 0xFFFFFFFF while it is 1. Each change of a20_en_i pulses tlb_flush_o.
- R11: A write with wr_sel_i = 3 loads only efer_o bit 8 from wr_data_i bit 8. efer_o bit 10 is not affected by the write, and all other efer_o bits read 0.
- R12: tlb_flush_o, ip_trunc_o and mode_fault_o are one-cycle pulses that appear in the cycle after the triggering edge. ip_trunc_o and mode_fault_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Target: 0 CR0, 1 CR3, 2 CR4, 3 extended feature |
| wr_data_i | input | 64 | Write data |
| a20_en_i | input | 1 | Address line 20 enable |
| sse_avail_i | input | 1 | Strap: streaming SIMD supported |
| cs64_set_i | input | 1 | Code segment loaded with 64-bit attribute |
| cr0_o | output | 32 | CR0 value |
| cr3_o | output | 64 | CR3 value |
| cr4_o | output | 32 | CR4 value |
| efer_o | output | 64 | Extended feature value (bit 8 enable, bit 10 active) |
| a20_mask_o | output | 32 | Physical address mask |
| pe_o | output | 1 | Hidden protected-mode flag |
| addseg_o | output | 1 | Hidden segment-base-add flag |
| mp_o | output | 1 | Hidden monitor-coprocessor flag |
| em_o | output | 1 | Hidden emulate-coprocessor flag |
| ts_o | output | 1 | Hidden task-switched flag |
| lma_o | output | 1 | Hidden long-mode-active flag |
| cs64_o | output | 1 | Hidden 64-bit code flag |
| osfxsr_o | output | 1 | Hidden extended save-state flag |
| ip_trunc_o | output | 1 | Pulse: truncate instruction pointer to 32 bits |
| tlb_flush_o | output | 1 | Pulse: flush translation cache |
| mode_fault_o | output | 1 | Pulse: long-mode entry refused |

## Verification
The hardest case to reach is the pair of paging transitions that depend on other registers. A refused entry needs the enable bit set, PAE clear and paging off all at once. A clean exit needs long mode to have been entered first, and the 64-bit code flag set in between. A directed opening sequence sets these up in order: enable bit, refused paging write, PAE, accepted paging write, code flag, then paging off. A long random phase follows with an even chance of each register and frequent paging toggles, so entries, refusals and exits keep recurring against a behavioural model.

// File: rtl/ctrl_reg_pkg.sv
package ctrl_reg_pkg;
  localparam int CR_W = 32;

  typedef enum logic [1:0] {
    SEL_CR0  = 2'd0,
    SEL_CR3  = 2'd1,
    SEL_CR4  = 2'd2,
    SEL_EFER = 2'd3
  } ctl_sel_e;

  localparam int CR0_PE = 0;
  localparam int CR0_MP = 1;
  localparam int CR0_EM = 2;
  localparam int CR0_TS = 3;
  localparam int CR0_ET = 4;
  localparam int CR0_WP = 16;
  localparam int CR0_PG = 31;

  localparam int CR4_PSE    = 4;
  localparam int CR4_PAE    = 5;
  localparam int CR4_PGE    = 7;
  localparam int CR4_OSFXSR = 9;

  localparam int EFER_LME = 8;
  localparam int EFER_LMA = 10;

  localparam logic [CR_W-1:0] CR0_RST = 32'h6000_0010;

  typedef struct packed {
    logic pe;
    logic addseg;
    logic mp;
    logic em;
    logic ts;
  } cr0_hid_t;
endpackage

// File: rtl/cr0_unit.sv
module cr0_unit
  import ctrl_reg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [CR_W-1:0] data_i,
  input  logic            lme_i,
  input  logic            pae_i,
  input  logic            cs64_set_i,
  output logic [CR_W-1:0] cr0_o,
  output cr0_hid_t        hid_o,
  output logic            lma_o,
  output logic            cs64_o,
  output logic            flush_o,
  output logic            trunc_o,
  output logic            fault_o
);
  localparam logic [CR_W-1:0] ET_BIT    = CR_W'(1) << CR0_ET;
  localparam logic [CR_W-1:0] MODE_MASK = (CR_W'(1) << CR0_PG) |
                                          (CR_W'(1) << CR0_WP) |
                                          (CR_W'(1) << CR0_PE);

  logic [CR_W-1:0] cr0_q, nv;
  cr0_hid_t        hid_q;
  logic            lma_q, cs64_q, flush_q, trunc_q, fault_q;
  logic            enter, leave, refuse, accept, mode_chg;

  always_comb begin
    nv       = data_i | ET_BIT;
    enter    = wr_i && !cr0_q[CR0_PG] && nv[CR0_PG] && lme_i;
    leave    = wr_i && cr0_q[CR0_PG] && !nv[CR0_PG] && lma_q;
    refuse   = enter && !pae_i;
    accept   = wr_i && !refuse;
    mode_chg = accept && (((nv ^ cr0_q) & MODE_MASK) != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr0_q   <= CR0_RST;
      hid_q   <= '{pe: 1'b0, addseg: 1'b1, mp: 1'b0, em: 1'b0, ts: 1'b0};
      lma_q   <= 1'b0;
      cs64_q  <= 1'b0;
      flush_q <= 1'b0;
      trunc_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      flush_q <= mode_chg;
      trunc_q <= leave;
      fault_q <= refuse;
      if (accept) begin
        cr0_q      <= nv;
        hid_q.pe     <= nv[CR0_PE];
        hid_q.addseg <= !nv[CR0_PE];
        hid_q.mp     <= nv[CR0_MP];
        hid_q.em     <= nv[CR0_EM];
        hid_q.ts     <= nv[CR0_TS];
      end
      if (enter && !refuse) lma_q <= 1'b1;
      else if (leave)       lma_q <= 1'b0;
      if (leave)                       cs64_q <= 1'b0;
      else if (cs64_set_i && lma_q)    cs64_q <= 1'b1;
    end
  end

  assign cr0_o   = cr0_q;
  assign hid_o   = hid_q;
  assign lma_o   = lma_q;
  assign cs64_o  = cs64_q;
  assign flush_o = flush_q;
  assign trunc_o = trunc_q;
  assign fault_o = fault_q;

  a_r2_et_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> cr0_q[CR0_ET]);
  a_r3_pe_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hid_q.pe == cr0_q[CR0_PE]) && (hid_q.addseg == !cr0_q[CR0_PE]));
  a_r5_refuse_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q |-> ($stable(cr0_q) && !flush_q));
  a_r5_lma_needs_pg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lma_q |-> cr0_q[CR0_PG]);
  a_r6_exit_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trunc_q |-> (!lma_q && !cs64_q && !cr0_q[CR0_PG]));
  a_r7_cs64_in_long: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs64_q |-> lma_q);
endmodule

// File: rtl/cr4_unit.sv
module cr4_unit
  import ctrl_reg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [CR_W-1:0] data_i,
  input  logic            sse_i,
  output logic [CR_W-1:0] cr4_o,
  output logic            osfxsr_o,
  output logic            flush_o
);
  localparam logic [CR_W-1:0] PG_MASK = (CR_W'(1) << CR4_PGE) |
                                        (CR_W'(1) << CR4_PAE) |
                                        (CR_W'(1) << CR4_PSE);
  localparam logic [CR_W-1:0] FX_BIT  = CR_W'(1) << CR4_OSFXSR;

  logic [CR_W-1:0] cr4_q, nv;
  logic            osfxsr_q, flush_q;

  always_comb begin
    nv = sse_i ? data_i : (data_i & ~FX_BIT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr4_q    <= '0;
      osfxsr_q <= 1'b0;
      flush_q  <= 1'b0;
    end else begin
      flush_q <= wr_i && (((nv ^ cr4_q) & PG_MASK) != '0);
      if (wr_i) begin
        cr4_q    <= nv;
        osfxsr_q <= nv[CR4_OSFXSR];
      end
    end
  end

  assign cr4_o    = cr4_q;
  assign osfxsr_o = osfxsr_q;
  assign flush_o  = flush_q;

  a_r8_osfxsr_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osfxsr_q == cr4_q[CR4_OSFXSR]);
  a_r8_no_sse_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sse_i) |=> !cr4_q[CR4_OSFXSR]);
endmodule

// File: rtl/a20_gate.sv
module a20_gate #(
  parameter int ADDR_W  = 32,
  parameter int A20_BIT = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic [ADDR_W-1:0] mask_o,
  output logic              flush_o
);
  localparam logic [ADDR_W-1:0] MASK_OFF = ~(ADDR_W'(1) << A20_BIT);

  logic state_q, flush_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= 1'b1;
      flush_q <= 1'b0;
    end else begin
      flush_q <= en_i != state_q;
      state_q <= en_i;
    end
  end

  assign mask_o  = state_q ? '1 : MASK_OFF;
  assign flush_o = flush_q;

  a_r10_flush_on_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_q |-> (state_q != $past(state_q)));
  a_r10_mask_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_o[A20_BIT] == state_q);
endmodule

// File: rtl/ctrl_reg_unit.sv
module ctrl_reg_unit
  import ctrl_reg_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int ADDR_W  = 32,
  parameter int A20_BIT = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [XLEN-1:0]   wr_data_i,
  input  logic              a20_en_i,
  input  logic              sse_avail_i,
  input  logic              cs64_set_i,
  output logic [CR_W-1:0]   cr0_o,
  output logic [XLEN-1:0]   cr3_o,
  output logic [CR_W-1:0]   cr4_o,
  output logic [XLEN-1:0]   efer_o,
  output logic [ADDR_W-1:0] a20_mask_o,
  output logic              pe_o,
  output logic              addseg_o,
  output logic              mp_o,
  output logic              em_o,
  output logic              ts_o,
  output logic              lma_o,
  output logic              cs64_o,
  output logic              osfxsr_o,
  output logic              ip_trunc_o,
  output logic              tlb_flush_o,
  output logic              mode_fault_o
);
  ctl_sel_e        sel;
  logic            wr_cr0, wr_cr3, wr_cr4, wr_efer;
  logic            lme_q, cr3_flush_q;
  logic [XLEN-1:0] cr3_q;
  logic            f_cr0, f_cr4, f_a20, lma;
  cr0_hid_t        hid;
  logic [CR_W-1:0] cr0, cr4;

  always_comb begin
    sel     = ctl_sel_e'(wr_sel_i);
    wr_cr0  = wr_en_i && (sel == SEL_CR0);
    wr_cr3  = wr_en_i && (sel == SEL_CR3);
    wr_cr4  = wr_en_i && (sel == SEL_CR4);
    wr_efer = wr_en_i && (sel == SEL_EFER);
  end

  cr0_unit u_cr0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_cr0),
    .data_i     (wr_data_i[CR_W-1:0]),
    .lme_i      (lme_q),
    .pae_i      (cr4[CR4_PAE]),
    .cs64_set_i (cs64_set_i),
    .cr0_o      (cr0),
    .hid_o      (hid),
    .lma_o      (lma),
    .cs64_o     (cs64_o),
    .flush_o    (f_cr0),
    .trunc_o    (ip_trunc_o),
    .fault_o    (mode_fault_o)
  );

  cr4_unit u_cr4 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_cr4),
    .data_i   (wr_data_i[CR_W-1:0]),
    .sse_i    (sse_avail_i),
    .cr4_o    (cr4),
    .osfxsr_o (osfxsr_o),
    .flush_o  (f_cr4)
  );

  a20_gate #(.ADDR_W(ADDR_W), .A20_BIT(A20_BIT)) u_a20 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (a20_en_i),
    .mask_o  (a20_mask_o),
    .flush_o (f_a20)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr3_q       <= '0;
      lme_q       <= 1'b0;
      cr3_flush_q <= 1'b0;
    end else begin
      cr3_flush_q <= wr_cr3 && cr0[CR0_PG];
      if (wr_cr3)  cr3_q <= wr_data_i;
      if (wr_efer) lme_q <= wr_data_i[EFER_LME];
    end
  end

  always_comb begin
    efer_o           = '0;
    efer_o[EFER_LME] = lme_q;
    efer_o[EFER_LMA] = lma;
  end

  assign cr0_o       = cr0;
  assign cr4_o       = cr4;
  assign cr3_o       = cr3_q;
  assign lma_o       = lma;
  assign pe_o        = hid.pe;
  assign addseg_o    = hid.addseg;
  assign mp_o        = hid.mp;
  assign em_o        = hid.em;
  assign ts_o        = hid.ts;
  assign tlb_flush_o = f_cr0 | f_cr4 | f_a20 | cr3_flush_q;

  a_r9_cr3_flush_pg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr3_flush_q |-> $past(cr0[CR0_PG]));
  a_r11_efer_keeps_lma: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_efer |=> $stable(lma));
  a_r12_pulse_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ip_trunc_o && mode_fault_o));
endmodule

// File: tb/tb_ctrl_reg_unit.sv
module tb_ctrl_reg_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [63:0] wr_data = '0;
  logic        a20_en = 1'b1;
  logic        sse = 1'b1;
  logic        cs64_set = 1'b0;

  logic [31:0] cr0, cr4, mask;
  logic [63:0] cr3, efer;
  logic pe, addseg, mp, em, ts, lma, cs64, osfxsr, trunc, flush, fault;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  ctrl_reg_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .a20_en_i(a20_en), .sse_avail_i(sse),
    .cs64_set_i(cs64_set), .cr0_o(cr0), .cr3_o(cr3), .cr4_o(cr4),
    .efer_o(efer), .a20_mask_o(mask), .pe_o(pe), .addseg_o(addseg),
    .mp_o(mp), .em_o(em), .ts_o(ts), .lma_o(lma), .cs64_o(cs64),
    .osfxsr_o(osfxsr), .ip_trunc_o(trunc), .tlb_flush_o(flush),
    .mode_fault_o(fault)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_cr0, m_cr4;
  logic [63:0] m_cr3;
  logic m_lme, m_lma, m_cs64, m_a20, m_flush, m_trunc, m_fault;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cr0 = 32'h6000_0010; m_cr4 = 0; m_cr3 = 0;
      m_lme = 0; m_lma = 0; m_cs64 = 0; m_a20 = 1;
      m_flush = 0; m_trunc = 0; m_fault = 0;
    end else begin
      logic [31:0] nv;
      logic go_in, go_out;
      m_flush = 0; m_trunc = 0; m_fault = 0;
      if (a20_en != m_a20) begin m_a20 = a20_en; m_flush = 1; end
      if (cs64_set && m_lma) m_cs64 = 1;
      if (wr_en) begin
        case (wr_sel)
          2'd0: begin
            nv = wr_data[31:0] | 32'h10;
            go_in  = !m_cr0[31] && nv[31] && m_lme;
            go_out = m_cr0[31] && !nv[31] && m_lma;
            if (go_in && !m_cr4[5]) m_fault = 1;
            else begin
              if (((nv ^ m_cr0) & 32'h8001_0001) != 0) m_flush = 1;
              if (go_in) m_lma = 1;
              if (go_out) begin m_lma = 0; m_cs64 = 0; m_trunc = 1; end
              m_cr0 = nv;
            end
          end
          2'd1: begin
            m_cr3 = wr_data;
            if (m_cr0[31]) m_flush = 1;
          end
          2'd2: begin
            nv = wr_data[31:0];
            if (!sse) nv[9] = 0;
            if (((nv ^ m_cr4) & 32'hB0) != 0) m_flush = 1;
            m_cr4 = nv;
          end
          default: m_lme = wr_data[8];
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 cr0", cr0, m_cr0);
      chk("R2 fpu flags", {mp, em, ts}, {m_cr0[1], m_cr0[2], m_cr0[3]});
      chk("R3 pe/addseg", {pe, addseg}, {m_cr0[0], !m_cr0[0]});
      chk("R9 cr3", cr3, m_cr3);
      chk("R8 cr4", cr4, m_cr4);
      chk("R8 osfxsr", osfxsr, m_cr4[9]);
      chk("R11 efer", efer, (64'(m_lme) << 8) | (64'(m_lma) << 10));
      chk("R5 lma", lma, m_lma);
      chk("R7 cs64", cs64, m_cs64);
      chk("R10 mask", mask, m_a20 ? 32'hFFFF_FFFF : 32'hFFEF_FFFF);
      chk("R4 flush", flush, m_flush);
      chk("R6 trunc", trunc, m_trunc);
      chk("R5 fault", fault, m_fault);
    end
  end

  task automatic do_wr(input logic [1:0] s, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cr0", cr0, 64'h6000_0010);
    chk("R1 mask", mask, 64'hFFFF_FFFF);
    chk("R1 regs", {cr3, efer}, 0);
    chk("R1 flags", {pe, addseg, mp, em, ts, lma, cs64, osfxsr}, 8'b0100_0000);
    chk("R1 pulses", {trunc, flush, fault}, 0);
    rst_n = 1;

    do_wr(2'd3, 64'h100);
    do_wr(2'd0, 64'h8000_0011);
    chk("R5 refused fault", fault, 1);
    chk("R5 refused cr0", cr0, 64'h6000_0010);
    chk("R5 refused noflush", flush, 0);
    @(negedge clk);
    chk("R12 fault one cycle", fault, 0);

    do_wr(2'd2, 64'h20);
    do_wr(2'd0, 64'h8000_0011);
    chk("R5 entry lma", lma, 1);
    chk("R4 entry flush", flush, 1);
    @(negedge clk);
    chk("R12 flush one cycle", flush, 0);
    cs64_set = 1;
    @(negedge clk);
    cs64_set = 0;
    chk("R7 cs64 set", cs64, 1);
    do_wr(2'd1, 64'h1234_5000);
    chk("R9 cr3 flush with pg", flush, 1);
    do_wr(2'd0, 64'h11);
    chk("R6 exit trunc", trunc, 1);
    chk("R6 exit clears", {lma, cs64}, 0);
    do_wr(2'd1, 64'h8000);
    chk("R9 cr3 no flush", flush, 0);
    do_wr(2'd0, 64'h11);
    chk("R4 same value no flush", flush, 0);
    sse = 0;
    do_wr(2'd2, 64'h2B0);
    chk("R8 osfxsr cleared", {cr4[9], osfxsr}, 0);
    sse = 1;
    do_wr(2'd3, 64'h0);
    chk("R11 efer only lme", efer, 0);
    @(negedge clk);
    a20_en = 0;
    @(negedge clk);
    chk("R10 a20 off mask", mask, 64'hFFEF_FFFF);
    chk("R10 a20 flush", flush, 1);
    a20_en = 1;
    @(negedge clk);

    for (int i = 0; i < 4000; i++) begin
      wr_en    = ($urandom % 3) != 0;
      wr_sel   = 2'($urandom % 4);
      wr_data  = {$urandom, $urandom};
      cs64_set = ($urandom % 4) == 0;
      if (($urandom % 16) == 0) a20_en = ~a20_en;
      if (($urandom % 32) == 0) sse = ~sse;
      @(negedge clk);
    end
    wr_en = 0; cs64_set = 0;
    @(negedge clk);
    finish_run();
  end
endmodule